// File: doc/BRIEF.md
# Keyboard Scancode Receiver and Decoder

This block sits between a keyboard byte source and a host bus. Each scancode byte arrives on a one-cycle valid strobe. The byte is stored in a single holding register. While a byte is waiting, the block raises an interrupt request meant for line 1 of the primary interrupt controller, which the CPU sees as vector 33 when the controller offset is 32. The host fetches the byte with a read at a configurable port address, which is 0x60 in the usual setup. The request stays raised until that read happens. A byte that arrives while the register is still occupied is dropped, and a sticky overrun flag records the loss.

Alongside the holding path, a stateful decoder interprets every incoming byte as scan code set 1. A byte equal to the escape prefix (0xE0) produces no event. Instead it marks the next byte as an extended key. Every other byte yields a one-cycle key event. The event carries the 7-bit key code, a release flag, the extended flag and an optional ASCII digit for the number-row keys.

Top module: `kbd_scan_rx`

## Requirements
- R1: After reset, `irq`, `overrun` and `evt_valid` are 0.
- R2: A byte accepted while the holding register is empty raises `irq` on the next cycle. A later read with `host_rd`=1 and `host_addr`=PORT_ADDR returns that byte on `host_rdata` in the same cycle.
- R3: Once raised, `irq` stays 1 until a read at PORT_ADDR. That read, with no byte arriving in the same cycle, clears `irq` on the next cycle.
- R4: A byte arriving while `irq` is 1, with no read in that cycle, is dropped: the held byte is unchanged and `overrun` becomes 1. `overrun` stays 1 until the next read at PORT_ADDR, which clears it.
- R5: A read at any address other than PORT_ADDR returns 0 and changes neither `irq`, `overrun` nor the held byte.
- R6: A byte other than 0xE0 produces `evt_valid`=1 for exactly the next cycle. In that event `evt_key` is byte bits 6:0 and `evt_release` is byte bit 7 (0 = press, 1 = release).
- R7: A 0xE0 byte produces no event and sets the escape state, so the next non-prefix event has `evt_ext`=1. That event clears the state, so the event after it has `evt_ext`=0. A repeated 0xE0 keeps the state set.
- R8: Key codes 0x02 to 0x0A give `evt_digit_valid`=1 with `evt_ascii` = '1' to '9'. Code 0x0B gives '0' (0x30). All other codes give `evt_digit_valid`=0 and `evt_ascii`=0. The code alone decides this, for both press and release.
- R9: A read at PORT_ADDR in the same cycle as an arriving byte, while a byte is held, returns the old byte and stores the new one. `irq` stays 1 and `overrun` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | One-cycle strobe for an incoming scancode byte |
| byte_data | input | 8 | Incoming scancode byte |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host read address |
| host_rdata | output | 8 | Held byte when PORT_ADDR is read, otherwise 0 |
| irq | output | 1 | Interrupt request: a byte is waiting |
| overrun | output | 1 | Sticky flag for a dropped byte |
| evt_valid | output | 1 | Decoded key event strobe |
| evt_key | output | 7 | Key code of the event |
| evt_release | output | 1 | 1 for a release, 0 for a press |
| evt_ext | output | 1 | Event was preceded by the escape prefix |
| evt_digit_valid | output | 1 | Key code maps to a number-row digit |
| evt_ascii | output | 8 | ASCII digit, 0 when there is none |

## Verification
The bench builds the block with ADDR_W=8, PORT_ADDR=0x60 and digit decoding enabled. The narrow address lets random reads land on both the data port and its near neighbours, so accesses to other addresses are exercised alongside real fetches. Random byte traffic is biased toward 0xE0 and the number-row codes, so that runs of consecutive prefixes occur. The bias also produces arrivals while a byte is held and reads that coincide with an arrival, which puts the overrun and same-cycle paths in reach together with the extended-key sequences.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;

   typedef struct packed {
      logic [6:0] key;
      logic       rel;
      logic       ext;
      logic       digit_ok;
      logic [7:0] ascii;
   } key_evt_t;

   function automatic logic code_is_digit(input logic [6:0] code);
      return (code >= 7'h02) && (code <= 7'h0B);
   endfunction

   function automatic logic [7:0] code_to_ascii(input logic [6:0] code);
      if (code >= 7'h02 && code <= 7'h0A)
         return 8'(8'h2F + {1'b0, code});
      else if (code == 7'h0B)
         return 8'h30;
      else
         return 8'h00;
   endfunction

endpackage

// File: rtl/kbd_holdreg.sv
module kbd_holdreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   input  logic              rd_hit,
   output logic [DATA_W-1:0] held_byte,
   output logic              full,
   output logic              ovr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_byte <= '0;
         full      <= 1'b0;
         ovr       <= 1'b0;
      end else if (rd_hit) begin
         full <= in_valid;
         ovr  <= 1'b0;
         if (in_valid) held_byte <= in_byte;
      end else if (in_valid) begin
         if (full) begin
            ovr <= 1'b1;
         end else begin
            full      <= 1'b1;
            held_byte <= in_byte;
         end
      end
   end

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      full && !rd_hit |=> full); // R3
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit && !in_valid |=> !full && !ovr); // R3
   AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      full && in_valid && !rd_hit |=> ovr && $stable(held_byte)); // R4
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovr && !rd_hit |=> ovr); // R4
   AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> full); // R4
   AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit && in_valid |=> full && !ovr); // R9

endmodule

// File: rtl/kbd_set1_decoder.sv
module kbd_set1_decoder
   import kbd_scan_pkg::*;
#(
   parameter logic [7:0] ESC_BYTE     = 8'hE0,
   parameter int         DIGIT_DECODE = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   output logic       evt_valid,
   output key_evt_t   evt
);

   logic       esc_q;
   logic       is_prefix;
   logic       dig_ok;
   logic [7:0] dig_ch;

   assign is_prefix = (in_byte == ESC_BYTE);

   generate
      if (DIGIT_DECODE != 0) begin : g_digits
         assign dig_ok = code_is_digit(in_byte[6:0]);
         assign dig_ch = code_to_ascii(in_byte[6:0]);
      end else begin : g_no_digits
         assign dig_ok = 1'b0;
         assign dig_ch = 8'h00;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         esc_q     <= 1'b0;
         evt_valid <= 1'b0;
         evt       <= '0;
      end else begin
         evt_valid <= 1'b0;
         if (in_valid) begin
            if (is_prefix) begin
               esc_q <= 1'b1;
            end else begin
               esc_q        <= 1'b0;
               evt_valid    <= 1'b1;
               evt.key      <= in_byte[6:0];
               evt.rel      <= in_byte[7];
               evt.ext      <= esc_q;
               evt.digit_ok <= dig_ok;
               evt.ascii    <= dig_ch;
            end
         end
      end
   end

   AST_EVT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !is_prefix |=> evt_valid && evt.key == $past(in_byte[6:0])
                                 && evt.rel == $past(in_byte[7])); // R6
   AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !evt_valid); // R6
   AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && is_prefix |=> !evt_valid); // R7
   AST_EXT_AFTER_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_prefix) ##1 (in_valid && !is_prefix) |=> evt.ext); // R7
   AST_DIGIT_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid && !evt.digit_ok |-> evt.ascii == 8'h00); // R8

endmodule

// File: rtl/kbd_scan_rx.sv
module kbd_scan_rx
   import kbd_scan_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter logic [31:0] PORT_ADDR    = 32'h0000_0060,
   parameter logic [7:0]  ESC_BYTE     = 8'hE0,
   parameter int          DIGIT_DECODE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_valid,
   input  logic [7:0]        byte_data,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   output logic [7:0]        host_rdata,
   output logic              irq,
   output logic              overrun,
   output logic              evt_valid,
   output logic [6:0]        evt_key,
   output logic              evt_release,
   output logic              evt_ext,
   output logic              evt_digit_valid,
   output logic [7:0]        evt_ascii
);

   localparam int                DATA_W   = 8;
   localparam logic [ADDR_W-1:0] MY_ADDR  = PORT_ADDR[ADDR_W-1:0];

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
         $error("kbd_scan_rx: ADDR_W must lie in 1..32");
      end
      if ((PORT_ADDR >> ADDR_W) != 0) begin : g_bad_port
         $error("kbd_scan_rx: PORT_ADDR does not fit in ADDR_W bits");
      end
      if (DIGIT_DECODE != 0 && DIGIT_DECODE != 1) begin : g_bad_digit
         $error("kbd_scan_rx: DIGIT_DECODE must be 0 or 1");
      end
   endgenerate

   logic              rd_hit;
   logic [DATA_W-1:0] held;
   key_evt_t          evt;

   assign rd_hit = host_rd && (host_addr == MY_ADDR);

   kbd_holdreg #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (byte_valid),
      .in_byte   (byte_data),
      .rd_hit    (rd_hit),
      .held_byte (held),
      .full      (irq),
      .ovr       (overrun)
   );

   kbd_set1_decoder #(.ESC_BYTE(ESC_BYTE), .DIGIT_DECODE(DIGIT_DECODE)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (byte_valid),
      .in_byte   (byte_data),
      .evt_valid (evt_valid),
      .evt       (evt)
   );

   assign host_rdata      = rd_hit ? held : 8'h00;
   assign evt_key         = evt.key;
   assign evt_release     = evt.rel;
   assign evt_ext         = evt.ext;
   assign evt_digit_valid = evt.digit_ok;
   assign evt_ascii       = evt.ascii;

   AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> host_rdata == 8'h00); // R5
   AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit && !byte_valid |=> $stable(irq) && $stable(overrun)); // R5
   AST_RAISE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid && !irq |=> irq); // R2

endmodule

// File: tb/tb_kbd_scan_rx.sv
module tb_kbd_scan_rx;

   localparam int          AW   = 8;
   localparam logic [7:0]  PORT = 8'h60;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          byte_valid = 1'b0;
   logic [7:0]    byte_data = 8'h00;
   logic          host_rd = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [7:0]    host_rdata;
   logic          irq, overrun, evt_valid, evt_release, evt_ext, evt_digit_valid;
   logic [6:0]    evt_key;
   logic [7:0]    evt_ascii;

   int checks = 0;
   int failures = 0;

   // reference state
   logic       m_full = 0, m_ovr = 0, m_esc = 0, m_ev = 0;
   logic [7:0] m_data = 0;
   logic [6:0] m_key = 0;
   logic       m_rel = 0, m_ext = 0, m_dok = 0;
   logic [7:0] m_asc = 0;

   kbd_scan_rx #(.ADDR_W(AW), .PORT_ADDR(32'h60), .ESC_BYTE(8'hE0), .DIGIT_DECODE(1)) dut (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
      .host_rd(host_rd), .host_addr(host_addr), .host_rdata(host_rdata),
      .irq(irq), .overrun(overrun), .evt_valid(evt_valid), .evt_key(evt_key),
      .evt_release(evt_release), .evt_ext(evt_ext), .evt_digit_valid(evt_digit_valid),
      .evt_ascii(evt_ascii)
   );

   always #2 clk = ~clk;

   function automatic logic [7:0] exp_ascii(input logic [6:0] c);
      if (c == 7'h0B) return 8'h30;
      if (c >= 7'h02 && c <= 7'h0A) return 8'h31 + 8'(c - 7'h02);
      return 8'h00;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic check_regs();
      chk("R3 irq", 32'(irq), 32'(m_full));
      chk("R4 overrun", 32'(overrun), 32'(m_ovr));
      chk("R6 evt_valid", 32'(evt_valid), 32'(m_ev));
      if (m_ev) begin
         chk("R6 key", 32'(evt_key), 32'(m_key));
         chk("R6 release", 32'(evt_release), 32'(m_rel));
         chk("R7 ext", 32'(evt_ext), 32'(m_ext));
         chk("R8 digit_valid", 32'(evt_digit_valid), 32'(m_dok));
         chk("R8 ascii", 32'(evt_ascii), 32'(m_asc));
      end
   endtask

   task automatic step(input logic v, input logic [7:0] b, input logic rd, input logic [7:0] a);
      logic hit;
      @(negedge clk);
      check_regs();
      byte_valid = v; byte_data = b; host_rd = rd; host_addr = a;
      #1;
      hit = rd && (a == PORT);
      if (hit) chk("R2 rdata", 32'(host_rdata), 32'(m_data));
      else chk("R5 rdata", 32'(host_rdata), 32'h0);
      // next-state of the reference
      m_ev = 1'b0;
      if (v) begin
         if (b == 8'hE0) m_esc = 1'b1;
         else begin
            m_ev = 1'b1; m_key = b[6:0]; m_rel = b[7]; m_ext = m_esc;
            m_asc = exp_ascii(b[6:0]); m_dok = (m_asc != 8'h00); m_esc = 1'b0;
         end
      end
      if (hit) begin
         m_full = v; m_ovr = 1'b0;
         if (v) m_data = b;
      end else if (v) begin
         if (m_full) m_ovr = 1'b1;
         else begin m_full = 1'b1; m_data = b; end
      end
   endtask

   task automatic idle(); step(1'b0, 8'h00, 1'b0, 8'h00); endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      int seed;
      seed = 32'h1F2E3D;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 overrun", 32'(overrun), 0);
      chk("R1 evt_valid", 32'(evt_valid), 0);

      // R2 store and fetch
      step(1, 8'h1E, 0, 0);
      idle();
      step(0, 0, 1, PORT);          // returns 0x1E
      idle();                        // R3 irq cleared
      // R4 overrun
      step(1, 8'h02, 0, 0);
      step(1, 8'h03, 0, 0);          // dropped
      idle();
      step(0, 0, 1, PORT);          // returns 0x02, clears overrun
      // R5 read at other addresses
      step(1, 8'h82, 0, 0);
      step(0, 0, 1, 8'h61);
      step(0, 0, 1, 8'h64);
      step(0, 0, 1, PORT);
      // R7 prefix and double prefix
      step(1, 8'hE0, 1, PORT);
      step(1, 8'h1C, 1, PORT);
      step(1, 8'h1C, 1, PORT);
      step(1, 8'hE0, 1, PORT);
      step(1, 8'hE0, 1, PORT);
      step(1, 8'h9C, 1, PORT);
      idle();
      // R8 digit boundaries
      step(1, 8'h01, 1, PORT);
      step(1, 8'h02, 1, PORT);
      step(1, 8'h0A, 1, PORT);
      step(1, 8'h0B, 1, PORT);
      step(1, 8'h8B, 1, PORT);
      step(1, 8'h0C, 1, PORT);
      step(0, 0, 1, PORT);
      // R9 read coinciding with arrival while full
      step(1, 8'h11, 0, 0);
      step(1, 8'h22, 0, 0);          // overrun
      step(1, 8'h33, 1, PORT);       // old 0x11 returned, 0x33 stored
      idle();
      step(0, 0, 1, PORT);          // R9 returns 0x33
      idle();

      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic v, rd;
         logic [7:0] b, a;
         int sel;
         v = ($urandom % 3) != 0;
         sel = $urandom % 8;
         if (sel < 2) b = 8'hE0;
         else if (sel < 5) b = {1'($urandom), 7'(2 + $urandom % 11)};
         else b = 8'($urandom);
         rd = ($urandom % 3) == 0;
         a = (($urandom % 4) != 0) ? PORT : 8'(8'h5E + $urandom % 8);
         step(v, b, rd, a);
      end
      idle();
      idle();

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule